// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps finished-but-not-yet-retired instruction results in a circular buffer. Each result stays there until every older instruction has retired, so no speculative value reaches architectural state early. The issue stage claims an entry and gets back the entry index. That index is the rename tag that consumers hold. Execution units later write a result back by tag, which marks the entry ready. Consumers read operands straight from the buffer by tag.

Entries retire from the head, one per cycle and strictly in allocation order, through a valid/ready retire stream. The stream carries the entry kind, the destination register and the value. Register results go to the register file and store entries release their store. A branch that resolved correctly retires like any other entry. A mispredicted branch flushes every younger entry in the cycle it retires and hands its corrected target (held in the value field) to fetch.

Back-pressure rules are as follows. On the allocate side, an entry is taken on any clock edge where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` falls when the buffer is full or a flush is under way. On the retire side, the head leaves on any edge where `ret_valid` and `ret_ready` are both high. While `ret_ready` is low, the presented entry holds still. `DEPTH` must be a power of two.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `ret_valid` is 0 and `flush` is 0.
- R2: The tag returned on an accepted allocation is the current tail index. Successive accepted allocations return consecutive tags modulo `DEPTH`, starting at 0 after reset.
- R3: Once `DEPTH` entries are occupied, `alloc_ready` is 0 and an offered allocation is not taken.
- R4: A lookup returns, combinationally, the stored value and a ready flag for `look_tag`. The flag is 1 only for a valid entry whose result has been written.
- R5: Only the head entry is presented on the retire port, and only once its result is written. A younger ready entry waits behind an unready head.
- R6: While `ret_valid` is 1 and `ret_ready` is 0, `ret_valid`, `ret_kind`, `ret_dest` and `ret_value` hold steady.
- R7: Kind codes are 0 for register, 1 for store and 2 for branch. A branch whose completion carried mispredict=0 retires through the port with `flush` low.
- R8: When a branch completed with mispredict=1 retires, `flush` is 1 in that cycle and `flush_target` equals its value. Every younger entry is discarded, and the next allocation gets the tag following the branch.
- R9: An allocation and a retirement in the same cycle both take effect, leaving occupancy unchanged.
- R10: A completion aimed at a tag that is not currently allocated has no effect. Allocating that tag afterwards yields an unready entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue offers a new entry |
| alloc_ready | output | 1 | Buffer can take an entry this cycle |
| alloc_kind | input | 2 | Entry kind: 0 register, 1 store, 2 branch |
| alloc_dest | input | REG_AW | Destination register number |
| alloc_tag | output | TAG_W | Tag assigned to the offered entry |
| cmpl_valid | input | 1 | Result write-back strobe |
| cmpl_tag | input | TAG_W | Entry being completed |
| cmpl_value | input | DATA_W | Result, or corrected target for a branch |
| cmpl_mispred | input | 1 | Branch resolved against its prediction |
| look_tag | input | TAG_W | Operand lookup tag |
| look_value | output | DATA_W | Value held for the lookup tag |
| look_ready | output | 1 | Lookup entry holds a written result |
| ret_valid | output | 1 | Head entry is ready to retire |
| ret_ready | input | 1 | Consumer accepts the head entry |
| ret_kind | output | 2 | Kind of the head entry |
| ret_dest | output | REG_AW | Destination of the head entry |
| ret_value | output | DATA_W | Value of the head entry |
| flush | output | 1 | Mispredicted branch retiring; younger work discarded |
| flush_target | output | DATA_W | Corrected fetch address |

## Verification
The bench builds the block with `DEPTH`=4, `DATA_W`=16 and `REG_AW`=3. With four entries, the pointers wrap within a handful of allocations, and a full buffer is reached in four allocations. Head/tail wrap, the full stall, retiring while allocating and a flush that lands mid-ring therefore all come up within a short run. The narrow value field still fits a distinct target for each branch.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH),
  localparam int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          ret_fire,
  input  logic          flush,
  output logic [TW-1:0] head,
  output logic [TW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      head  <= head + 1'b1;
      tail  <= head + 1'b1;
      count <= '0;
    end else begin
      if (alloc_fire) tail <= tail + 1'b1;
      if (ret_fire)   head <= head + 1'b1;
      count <= count + CW'(alloc_fire) - CW'(ret_fire);
    end
  end

  assign full = (count == CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  assert_swap_keeps_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && ret_fire && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [TW-1:0]     alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [REG_AW-1:0] alloc_dest,
  input  logic              cmpl_valid,
  input  logic [TW-1:0]     cmpl_tag,
  input  logic [DATA_W-1:0] cmpl_value,
  input  logic              cmpl_mispred,
  input  logic              ret_fire,
  input  logic              flush,
  input  logic [TW-1:0]     head,
  input  logic [TW-1:0]     look_tag,
  output logic [DATA_W-1:0] look_value,
  output logic              look_ready,
  output logic              head_live,
  output logic              head_done,
  output rob_kind_e         head_kind,
  output logic [REG_AW-1:0] head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic              head_mis
);
  logic              live [DEPTH];
  logic              done [DEPTH];
  rob_kind_e         kind [DEPTH];
  logic [REG_AW-1:0] dest [DEPTH];
  logic [DATA_W-1:0] value[DEPTH];
  logic              mis  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic take, drop, fill;
    assign take = alloc_fire && (alloc_idx == TW'(i));
    assign drop = ret_fire && (head == TW'(i));
    assign fill = cmpl_valid && (cmpl_tag == TW'(i)) && live[i] && !take;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live[i] <= 1'b0;
        done[i] <= 1'b0;
      end else if (flush) begin
        live[i] <= 1'b0;
        done[i] <= 1'b0;
      end else if (take) begin
        live[i] <= 1'b1;
        done[i] <= 1'b0;
      end else if (drop) begin
        live[i] <= 1'b0;
        done[i] <= 1'b0;
      end else if (fill) begin
        done[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        kind[i] <= alloc_kind;
        dest[i] <= alloc_dest;
      end
      if (fill) begin
        value[i] <= cmpl_value;
        mis[i]   <= cmpl_mispred;
      end
    end
  end

  always_comb begin
    look_value = value[look_tag];
    look_ready = live[look_tag] && done[look_tag];
    head_live  = live[head];
    head_done  = done[head];
    head_kind  = kind[head];
    head_dest  = dest[head];
    head_value = value[head];
    head_mis   = mis[head];
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CW    = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_AW-1:0] alloc_dest,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic [DATA_W-1:0] cmpl_value,
  input  logic              cmpl_mispred,
  input  logic [TAG_W-1:0]  look_tag,
  output logic [DATA_W-1:0] look_value,
  output logic              look_ready,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [1:0]        ret_kind,
  output logic [REG_AW-1:0] ret_dest,
  output logic [DATA_W-1:0] ret_value,
  output logic              flush,
  output logic [DATA_W-1:0] flush_target
);
  logic [TAG_W-1:0] head, tail;
  logic [CW-1:0]    count;
  logic             full, alloc_fire, ret_fire;
  logic             head_live, head_done, head_mis;
  rob_kind_e        head_kind;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .ret_fire(ret_fire),
    .flush(flush), .head(head), .tail(tail), .count(count), .full(full)
  );

  rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_idx(tail), .alloc_kind(rob_kind_e'(alloc_kind)),
    .alloc_dest(alloc_dest),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
    .cmpl_mispred(cmpl_mispred),
    .ret_fire(ret_fire), .flush(flush), .head(head), .look_tag(look_tag),
    .look_value(look_value), .look_ready(look_ready),
    .head_live(head_live), .head_done(head_done), .head_kind(head_kind),
    .head_dest(ret_dest), .head_value(ret_value), .head_mis(head_mis)
  );

  assign alloc_ready  = !full && !flush;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign alloc_tag    = tail;
  assign ret_valid    = head_live && head_done;
  assign ret_fire     = ret_valid && ret_ready;
  assign ret_kind     = head_kind;
  assign flush        = ret_fire && (head_kind == KIND_BRANCH) && head_mis;
  assign flush_target = ret_value;

  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !alloc_ready);

  assert_retire_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_dest) &&
                                   $stable(ret_value) && $stable(ret_kind)));
endmodule

// File: tb/rob_core_tb.sv
module rob_core_tb;
  localparam int D = 4, DW = 16, RW = 3, TW = 2;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [1:0] alloc_kind = 0;
  logic [RW-1:0] alloc_dest = 0;
  logic [TW-1:0] alloc_tag;
  logic cmpl_valid = 0, cmpl_mispred = 0;
  logic [TW-1:0] cmpl_tag = 0, look_tag = 0;
  logic [DW-1:0] cmpl_value = 0, look_value, ret_value, flush_target;
  logic look_ready, ret_valid, rr = 0, flush;
  logic [1:0] ret_kind;
  logic [RW-1:0] ret_dest;

  always #10 clk = ~clk;

  rob_core #(.DEPTH(D), .DATA_W(DW), .REG_AW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
    .cmpl_mispred(cmpl_mispred), .look_tag(look_tag), .look_value(look_value),
    .look_ready(look_ready), .ret_valid(ret_valid), .ret_ready(rr),
    .ret_kind(ret_kind), .ret_dest(ret_dest), .ret_value(ret_value),
    .flush(flush), .flush_target(flush_target)
  );

  typedef struct { logic [1:0] k; logic [RW-1:0] d; logic [DW-1:0] v; bit m; int t; } item_t;
  item_t q[$];
  int pend[$];
  logic [DW-1:0] pv[D];
  bit pm[D];
  int checks = 0, fails = 0, exp_tag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare at the retire port
  always @(negedge clk) begin
    if (rst_n && ret_valid && rr) begin
      if (q.size() == 0) chk(0, "R5 unexpected retire", ret_dest, 0);
      else begin
        item_t e;
        e = q.pop_front();
        chk(ret_kind == e.k, "R5 kind", ret_kind, e.k);
        chk(ret_dest == e.d, "R5 dest", ret_dest, e.d);
        chk(ret_value == e.v, "R5 value", ret_value, e.v);
        chk(flush == e.m, "R7/R8 flush", flush, e.m);
        if (e.m) begin
          chk(flush_target == e.v, "R8 target", flush_target, e.v);
          q.delete();
          pend.delete();
          exp_tag = (e.t + 1) % D;
        end
      end
    end
  end

  task automatic alloc(input logic [1:0] k, input logic [RW-1:0] d,
                       input logic [DW-1:0] v, input bit m, input bit rr_on);
    item_t e;
    @(posedge clk); #2;
    alloc_valid = 1; alloc_kind = k; alloc_dest = d;
    if (rr_on) rr = 1;
    #1;
    chk(alloc_ready == 1, "R2 ready", alloc_ready, 1);
    chk(alloc_tag == TW'(exp_tag), "R2 tag", alloc_tag, exp_tag);
    e.k = k; e.d = d; e.v = v; e.m = m; e.t = exp_tag;
    q.push_back(e); pend.push_back(exp_tag);
    pv[exp_tag] = v; pm[exp_tag] = m;
    exp_tag = (exp_tag + 1) % D;
    @(posedge clk); #2;
    alloc_valid = 0;
    if (rr_on) rr = 0;
  endtask

  task automatic cmpl_raw(input int t, input logic [DW-1:0] v, input bit m);
    @(posedge clk); #2;
    cmpl_valid = 1; cmpl_tag = TW'(t); cmpl_value = v; cmpl_mispred = m;
    @(posedge clk); #2;
    cmpl_valid = 0;
  endtask

  task automatic complete(input int t);
    cmpl_raw(t, pv[t], pm[t]);
  endtask

  task automatic complete_all();
    while (pend.size() > 0) begin
      int t;
      t = pend.pop_front();
      complete(t);
    end
  endtask

  task automatic drain();
    @(posedge clk); #2; rr = 1;
    repeat (2 * D + 2) @(posedge clk);
    #2;
    chk(q.size() == 0, "R5 drained", q.size(), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(alloc_ready == 1, "R1 alloc_ready", alloc_ready, 1);
    chk(ret_valid == 0, "R1 ret_valid", ret_valid, 0);
    chk(flush == 0, "R1 flush", flush, 0);

    // in-order retire, lookup, hold
    alloc(2'd0, 3'd1, 16'h0011, 0, 0);
    alloc(2'd0, 3'd2, 16'h0022, 0, 0);
    alloc(2'd1, 3'd3, 16'h0033, 0, 0);
    complete(1);
    @(negedge clk);
    chk(ret_valid == 0, "R5 younger waits", ret_valid, 0);
    look_tag = 1; #1;
    chk(look_ready == 1 && look_value == 16'h0022, "R4 lookup done", look_value, 16'h22);
    look_tag = 0; #1;
    chk(look_ready == 0, "R4 lookup pending", look_ready, 0);
    complete(0);
    @(negedge clk);
    chk(ret_valid == 1, "R5 head ready", ret_valid, 1);
    begin
      logic [DW-1:0] hv; logic [RW-1:0] hd;
      hv = ret_value; hd = ret_dest;
      repeat (2) @(negedge clk);
      chk(ret_valid == 1 && ret_value == hv && ret_dest == hd, "R6 hold", ret_value, hv);
    end
    @(posedge clk); #2 rr = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ret_valid == 0, "R5 head not ready", ret_valid, 0);
    pend.delete(); pend.push_back(2);
    complete_all();
    drain();

    // ignored completion to an unallocated tag
    cmpl_raw(3, 16'h0077, 0);
    alloc(2'd0, 3'd4, 16'h0044, 0, 0);
    look_tag = 3; #1;
    chk(look_ready == 0, "R10 stale completion ignored", look_ready, 0);
    complete_all();
    drain();

    // fill to capacity with wrap
    @(posedge clk); #2 rr = 0;
    for (int i = 0; i < D; i++) alloc(2'd0, RW'(i), DW'(16'h100 + i), 0, 0);
    @(posedge clk); #2;
    alloc_valid = 1; #1;
    chk(alloc_ready == 0, "R3 full stall", alloc_ready, 0);
    @(posedge clk); #2 alloc_valid = 0;
    complete_all();
    drain();

    // allocate and retire in the same cycle
    @(posedge clk); #2 rr = 0;
    alloc(2'd1, 3'd5, 16'h0200, 0, 0);
    complete_all();
    alloc(2'd0, 3'd6, 16'h0201, 0, 1);
    begin
      int n;
      n = 0;
      for (int k = 0; k < 6; k++) begin
        @(posedge clk); #2;
        if (!alloc_ready) break;
        alloc(2'd0, 3'd7, DW'(16'h0300 + k), 0, 0);
        n++;
      end
      chk(n == D - 1, "R9 occupancy after swap", n, D - 1);
    end
    complete_all();
    drain();

    // correctly predicted branch
    alloc(2'd2, 3'd0, 16'h0080, 0, 0);
    complete_all();
    drain();

    // mispredicted branch flushes younger entries
    @(posedge clk); #2 rr = 0;
    begin
      int tb;
      tb = exp_tag;
      alloc(2'd2, 3'd0, 16'h1234, 1, 0);
      alloc(2'd0, 3'd5, 16'h0055, 0, 0);
      alloc(2'd0, 3'd6, 16'h0066, 0, 0);
      complete((tb + 1) % D);
      complete((tb + 2) % D);
      complete(tb);
      @(posedge clk); #2 rr = 1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(ret_valid == 0, "R8 younger discarded", ret_valid, 0);
      chk(exp_tag == (tb + 1) % D, "R8 flush seen", exp_tag, (tb + 1) % D);
      look_tag = TW'((tb + 2) % D); #1;
      chk(look_ready == 0, "R8 flushed entry gone", look_ready, 0);
      alloc(2'd0, 3'd7, 16'h0099, 0, 0);
      complete_all();
      drain();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule